// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a network receive path. It watches the destination address of each incoming frame as it arrives one byte per valid cycle and gives a single accept or reject verdict for the frame. The verdict combines three address classes. An exact comparison is made against the programmed station address. The all-ones broadcast address is detected. Group (multicast) addresses are looked up in a 64-bit hashed filter.

Configuration inputs set the policy for the verdict. A promiscuous override accepts every frame. The unicast path and the broadcast path each have their own disable, and neither disable affects the other path. The station address is held as three 16-bit words and the hash filter as four 16-bit words, both presented as flat vectors. The first byte of each address is marked by a start-of-frame flag. Bytes that follow the sixth address byte are ignored until the next start. The verdict appears as a one-cycle valid pulse carrying an accept bit.

Top module: `rx_dest_filter`

## Requirements
- R1: When `promisc` is 1, every completed address is accepted, whatever the other configuration inputs are.
- R2: An address whose six bytes all equal the station address is accepted unless `no_unicast` is 1. Byte k, counting from 0 for the first byte received, is compared with `sta_addr[8k+7:8k]`. `no_unicast` has no effect on broadcast or multicast verdicts.
- R3: The all-ones address is accepted unless `no_bcast` is 1. `no_bcast` has no effect on unicast or multicast verdicts.
- R4: A group address is accepted exactly when `hash_tbl[idx]` is 1. A group address has bit 0 of byte 0 equal to 1 and is not all ones. `idx` is bits 31:26 of a reflected CRC-32 taken over the six bytes in arrival order, least significant bit of each byte first. The CRC uses polynomial 32'hEDB88320, starts from all ones and is not inverted at the end. Filter word w is `hash_tbl[16w+15:16w]`.
- R5: An address with bit 0 of byte 0 equal to 0 that does not match the station address is rejected, whatever the hash filter holds (unless R1 applies).
- R6: The broadcast address is never tested against the hash filter. With `no_bcast` set, a broadcast address is rejected even if its hash bit is 1.
- R7: `decide_vld` is a one-cycle pulse in the cycle right after the one in which the sixth address byte is taken. Cycles with `da_valid` low do not count as bytes. Bytes after the sixth give no further verdict until the next start.
- R8: `da_valid` with `da_sof` always takes its byte as byte 0. A partial address is dropped and gives no verdict. `da_valid` without `da_sof` while no address is open is ignored.
- R9: After reset `decide_vld` and `decide_accept` are 0. `decide_accept` is 0 whenever `decide_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| da_valid | input | 1 | A destination address byte is present |
| da_sof | input | 1 | The present byte is the first of a new frame |
| da_byte | input | 8 | Address byte |
| promisc | input | 1 | Accept all frames |
| no_unicast | input | 1 | Disable the station address match |
| no_bcast | input | 1 | Disable broadcast acceptance |
| sta_addr | input | 48 | Station address, three 16-bit words |
| hash_tbl | input | 64 | Multicast hash filter, four 16-bit words |
| decide_vld | output | 1 | Verdict pulse |
| decide_accept | output | 1 | Verdict: 1 accepts the frame |

## Verification
The hardest case to reach from the ports is a group address whose hash bit is the one that decides the verdict, because the bit index comes from a CRC that cannot be read anywhere. The bench computes the index on its own, bit by bit over the whole 48-bit address. Per vector, it then programs the filter to hold only that bit, all bits but that bit, all zeros or all ones. With these fills, a wrong CRC, wrong bit order or wrong word layout turns an expected accept into a reject, or the other way round. Restarts in the middle of an address, gaps in `da_valid` and trailing bytes are driven by directed sequences after the vector table.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // Per-address hit summary, valid while the last byte is taken
  typedef struct packed {
    logic uni;
    logic bc;
    logic mc;
    logic grp;
  } rxf_hits_t;

  // One byte of the reflected CRC, least significant bit first
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r = {1'b0, r[CRC_W-1:1]};
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

  // Accept rule over the individual hits
  function automatic logic accept_rule(input rxf_hits_t h, input logic prom,
                                       input logic no_uni, input logic no_bc);
    return prom | (h.bc & ~no_bc) | (h.uni & ~no_uni) | h.mc;
  endfunction

endpackage

// File: rtl/rxf_byte_tracker.sv
module rxf_byte_tracker #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid,
  input  logic             da_sof,
  output logic             take,
  output logic [POS_W-1:0] pos,
  output logic             first,
  output logic             last
);

  localparam logic [POS_W-1:0] IDLE_POS = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic [POS_W-1:0] idx_q;

  // A start always opens byte 0; otherwise continue an open address
  assign pos   = da_sof ? '0 : idx_q;
  assign take  = da_valid & (da_sof | (idx_q < IDLE_POS));
  assign first = take & (pos == '0);
  assign last  = take & (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDLE_POS;
    end else if (take) begin
      idx_q <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/rxf_exact_cmp.sv
module rxf_exact_cmp #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned ADDR_W = ADDR_BYTES * 8,
  localparam int unsigned POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic              last,
  input  logic [POS_W-1:0]  pos,
  input  logic [7:0]        da_byte,
  input  logic [ADDR_W-1:0] sta_addr,
  output logic              uni_hit,
  output logic              bc_hit,
  output logic              grp_bit
);

  logic [7:0] sta_b [ADDR_BYTES];
  logic [7:0] cur_sta;
  logic       uni_run_q, ones_run_q, grp_q;
  logic       uni_run_nx, ones_run_nx;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta_bytes
    assign sta_b[g] = sta_addr[8*g +: 8];
  end

  always_comb begin
    cur_sta = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (pos == POS_W'(i)) cur_sta = sta_b[i];
    end
  end

  assign uni_run_nx  = (first ? 1'b1 : uni_run_q) & (da_byte == cur_sta);
  assign ones_run_nx = (first ? 1'b1 : ones_run_q) & (&da_byte);
  assign grp_bit     = first ? da_byte[0] : grp_q;

  // Hits are events: meaningful only while the last byte is taken
  assign uni_hit = last & uni_run_nx;
  assign bc_hit  = last & ones_run_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uni_run_q  <= 1'b0;
      ones_run_q <= 1'b0;
      grp_q      <= 1'b0;
    end else if (take) begin
      uni_run_q  <= uni_run_nx;
      ones_run_q <= ones_run_nx;
      grp_q      <= grp_bit;
    end
  end

endmodule

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [7:0]           da_byte,
  output logic [HASH_BITS-1:0] hash_idx
);

  logic [CRC_W-1:0] crc_q, crc_nx;

  assign crc_nx   = crc_step_byte(first ? CRC_SEED : crc_q, da_byte);
  assign hash_idx = crc_nx[CRC_W-1 -: HASH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (take) begin
      crc_q <= crc_nx;
    end
  end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  localparam int unsigned ADDR_W = ADDR_BYTES * 8,
  localparam int unsigned FILT_W = 1 << HASH_BITS,
  localparam int unsigned POS_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic              da_sof,
  input  logic [7:0]        da_byte,
  input  logic              promisc,
  input  logic              no_unicast,
  input  logic              no_bcast,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [FILT_W-1:0] hash_tbl,
  output logic              decide_vld,
  output logic              decide_accept
);

  logic                 take, first, addr_done;
  logic [POS_W-1:0]     pos;
  logic                 uni_hit, bc_hit, grp_bit, mc_hit;
  logic [HASH_BITS-1:0] hash_idx;
  rxf_hits_t            hits;
  logic                 vld_q, acc_q;

  rxf_byte_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof),
    .take(take), .pos(pos), .first(first), .last(addr_done)
  );

  rxf_exact_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .last(addr_done),
    .pos(pos), .da_byte(da_byte), .sta_addr(sta_addr),
    .uni_hit(uni_hit), .bc_hit(bc_hit), .grp_bit(grp_bit)
  );

  rxf_hash_crc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first),
    .da_byte(da_byte), .hash_idx(hash_idx)
  );

  // Broadcast is a group address too, but it never reaches the hash filter
  assign mc_hit = addr_done & grp_bit & ~bc_hit & hash_tbl[hash_idx];

  assign hits = '{uni: uni_hit, bc: bc_hit, mc: mc_hit, grp: grp_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= addr_done;
      acc_q <= addr_done & accept_rule(hits, promisc, no_unicast, no_bcast);
    end
  end

  assign decide_vld    = vld_q;
  assign decide_accept = acc_q;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rst_n,
  input logic addr_done,
  input logic uni_hit,
  input logic bc_hit,
  input logic mc_hit,
  input logic promisc,
  input logic no_unicast,
  input logic no_bcast,
  input logic decide_vld,
  input logic decide_accept
);

  p_promisc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && promisc |=> decide_accept);

  p_uni_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && uni_hit && no_unicast && !promisc && !bc_hit && !mc_hit |=> !decide_accept);

  p_bc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && bc_hit && no_bcast && !promisc && !(uni_hit && !no_unicast) |=> !decide_accept);

  p_mc_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_hit |=> decide_accept);

  p_bc_not_hashed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_hit |-> !mc_hit);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> decide_vld);

  p_vld_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    decide_vld |-> $past(addr_done));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    decide_vld |=> !decide_vld);

  p_acc_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decide_accept |-> decide_vld);

endmodule

bind rx_dest_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr_done(addr_done), .uni_hit(uni_hit),
  .bc_hit(bc_hit), .mc_hit(mc_hit), .promisc(promisc),
  .no_unicast(no_unicast), .no_bcast(no_bcast),
  .decide_vld(decide_vld), .decide_accept(decide_accept)
);

// File: tb/sim_rx_dest_filter.sv
module sim_rx_dest_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0, da_sof = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        promisc = 1'b0, no_unicast = 1'b0, no_bcast = 1'b0;
  logic [47:0] sta_addr;
  logic [63:0] hash_tbl = '0;
  logic        decide_vld, decide_accept;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [47:0] STA   = 48'hAB89_6745_2302;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UNI2  = 48'hAB89_6745_2402;
  localparam logic [47:0] MC1   = 48'h0000_5E00_0001;
  localparam logic [47:0] MC2   = 48'h1234_5678_9A33;

  // {addr, promisc, no_unicast, no_bcast, hash fill, expected accept}
  // hash fill: 0 zeros, 1 only own bit, 2 all but own bit, 3 all ones
  localparam int NV = 16;
  localparam logic [53:0] VEC [NV] = '{
    {STA,   1'b0, 1'b0, 1'b0, 2'd0, 1'b1},
    {STA,   1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
    {BCAST, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1},
    {BCAST, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0},
    {BCAST, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {UNI2,  1'b0, 1'b0, 1'b0, 2'd3, 1'b0},
    {MC1,   1'b0, 1'b0, 1'b0, 2'd1, 1'b1},
    {MC1,   1'b0, 1'b0, 1'b0, 2'd2, 1'b0},
    {MC2,   1'b0, 1'b1, 1'b1, 2'd1, 1'b1},
    {MC2,   1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
    {UNI2,  1'b1, 1'b0, 1'b0, 2'd0, 1'b1},
    {BCAST, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1},
    {STA,   1'b1, 1'b1, 1'b0, 2'd0, 1'b1},
    {MC1,   1'b1, 1'b0, 1'b0, 2'd0, 1'b1},
    {STA,   1'b0, 1'b0, 1'b1, 2'd0, 1'b1},
    {BCAST, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R3", "R3", "R6", "R5", "R4", "R4",
                                  "R4", "R4", "R1", "R1", "R1", "R1", "R2", "R3"};

  rx_dest_filter u0 (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .promisc(promisc), .no_unicast(no_unicast), .no_bcast(no_bcast),
    .sta_addr(sta_addr), .hash_tbl(hash_tbl),
    .decide_vld(decide_vld), .decide_accept(decide_accept)
  );

  always #4 clk = ~clk;

  // Hash index restated over the whole address, one bit at a time
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] r;
    logic fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      fb = r[0] ^ a[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r[31:26];
  endfunction

  function automatic logic [63:0] fill(input logic [1:0] mode, input logic [47:0] a);
    logic [63:0] own;
    own = 64'd1 << ref_index(a);
    case (mode)
      2'd0: return 64'd0;
      2'd1: return own;
      2'd2: return ~own;
      default: return '1;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Sends an address; gap idle cycles between bytes, ntrail bytes after it.
  task automatic send_addr(input logic [47:0] a, input int gap, input int ntrail,
                           output logic early, output logic got_vld,
                           output logic got_acc, output logic late);
    early = 0;
    late = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (decide_vld) early = 1;
      da_valid = 1'b1;
      da_sof = (k == 0);
      da_byte = a[8*k +: 8];
      if (k < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (decide_vld) early = 1;
          da_valid = 1'b0;
          da_sof = 1'b0;
          da_byte = 8'hFF;
        end
      end
    end
    @(negedge clk);
    got_vld = decide_vld;
    got_acc = decide_accept;
    da_valid = 1'b0;
    da_sof = 1'b0;
    for (int t = 0; t < ntrail + 2; t++) begin
      @(negedge clk);
      if (decide_vld) late = 1;
      da_valid = (t < ntrail);
      da_byte = 8'hFF;
    end
    da_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic e, v, ac, l;
    sta_addr = STA;
    repeat (3) @(negedge clk);
    check(!decide_vld && !decide_accept, "R9", "outputs in reset",
          {6'd0, decide_vld, decide_accept}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!decide_vld && !decide_accept, "R9", "outputs after reset",
          {6'd0, decide_vld, decide_accept}, 8'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [47:0] a;
      a = VEC[i][53:6];
      promisc = VEC[i][5];
      no_unicast = VEC[i][4];
      no_bcast = VEC[i][3];
      hash_tbl = fill(VEC[i][2:1], a);
      send_addr(a, 0, 0, e, v, ac, l);
      check(!e && v && !l, "R7", $sformatf("pulse timing vec %0d", i),
            {5'd0, e, v, l}, 8'b010);
      check(ac == VEC[i][0], VTAG[i], $sformatf("accept vec %0d", i), {7'd0, ac},
            {7'd0, VEC[i][0]});
    end

    // R7: gaps in da_valid and trailing bytes
    promisc = 1'b0; no_unicast = 1'b0; no_bcast = 1'b0; hash_tbl = '0;
    send_addr(STA, 2, 5, e, v, ac, l);
    check(!e && v && ac, "R7", "gapped station address", {5'd0, e, v, ac}, 8'b011);
    check(!l, "R7", "no verdict from trailing bytes", {7'd0, l}, 8'd0);

    // R8: bytes without a start while idle are ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!decide_vld, "R8", "no verdict without start", {7'd0, decide_vld}, 8'd0);
      da_valid = 1'b1;
      da_sof = 1'b0;
      da_byte = STA[8*(k%6) +: 8];
    end
    @(negedge clk);
    da_valid = 1'b0;
    @(negedge clk);
    check(!decide_vld, "R8", "idle bytes gave no verdict", {7'd0, decide_vld}, 8'd0);

    // R8: restart inside an address; partial station bytes then broadcast
    no_bcast = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      da_valid = 1'b1;
      da_sof = (k == 0);
      da_byte = STA[8*k +: 8];
    end
    send_addr(BCAST, 0, 0, e, v, ac, l);
    check(!e && v && !l, "R8", "one verdict after restart", {5'd0, e, v, l}, 8'b010);
    check(!ac, "R8", "restarted address judged alone", {7'd0, ac}, 8'd0);

    // R8: start of a new address one byte before completion
    no_bcast = 1'b0;
    no_unicast = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      da_valid = 1'b1;
      da_sof = (k == 0);
      da_byte = BCAST[8*k +: 8];
    end
    send_addr(STA, 0, 0, e, v, ac, l);
    check(!e && v && !ac, "R8", "late restart to disabled station",
          {5'd0, e, v, ac}, 8'b010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule